// File: doc/BRIEF.md
# N-plus-one countdown event timer

This block is a single programmable event timer. Software writes one control word that holds a start bit, a mode bit and a 29-bit count value. While the timer runs, it decrements once for every pulse of a 1 MHz timebase enable. The bus clock alone does not move it. A loaded value N produces an expiry on the (N+1)-th tick. Loading 0 therefore expires after a single tick, and loading the largest value gives an interval of 2^29 ticks.

On expiry the block sets a sticky status flag. Software clears that flag by writing a one to it. The interrupt pin is the flag gated by an interrupt-enable bit. In one-shot mode the timer stops itself on expiry. In periodic mode it reloads the stored count and keeps running. The live down-count can be read back at any time. Clearing the start bit halts the timer and raises no interrupt.

The register interface is a plain synchronous bus. A write is taken on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `nplus1_timer`

## Requirements
- R1: After reset every readable register returns 0 and `irq` is low.
- R2: A write to address 0 with bit 31 set loads the count from bits 28:0, stores it as the reload value, takes bit 30 as the mode (1 = periodic) and starts the timer. Bit 29 is ignored. Address 0 reads back {run, periodic, 0, reload value}.
- R3: After a start with count N, the expiry flag sets on exactly the (N+1)-th tick pulse, and not before.
- R4: A start with count 0 sets the flag on the first tick pulse.
- R5: The count changes only on clock edges where `tick_en` is high. A tick held high for k cycles counts k ticks.
- R6: In one-shot mode, expiry clears the run bit (address 0, bit 31) and leaves the count at 0. Later ticks set no further expiry.
- R7: In periodic mode, expiry reloads the stored value, and the flag sets again every N+1 ticks.
- R8: The flag reads at address 2, bit 30. It stays set until a write to address 2 with bit 30 set. A write there with bit 30 clear has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R9: `irq` is high exactly when the flag is set and the interrupt-enable bit (address 3, bit 0) is 1.
- R10: A write to address 0 with bit 31 clear stops the timer. The count is frozen, the other fields are ignored and no expiry follows.
- R11: Address 1 returns the live count, zero-extended to 32 bits.
- R12: The full 29-bit value 0x1FFFFFFF loads and counts down like any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 1 MHz timebase enable, one clock wide per tick |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt, flag AND interrupt-enable |

## Verification
The bench builds the block with its default 29-bit count. It sweeps every one-shot load value from 0 to 24 and every periodic load value from 0 to 5, comparing the live count and the flag after each single tick against values computed arithmetically from N. The all-ones 29-bit load is checked separately. Directed cases cover stopping mid-count, a held tick enable, an ignored write to the status register, and an expiry that coincides with a clear.

// File: rtl/nplus1_timer_pkg.sv
// Shared register map and bit positions of the n-plus-one event timer.
// Assumes a 32-bit data bus and four word registers.
package nplus1_timer_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int RUN_BIT  = 31;   // start / running bit in the control word
    localparam int MODE_BIT = 30;   // 1 = periodic, 0 = one-shot
    localparam int FLAG_BIT = 30;   // expiry flag position in the status word

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_COUNT = 2'd1,
        REG_STAT  = 2'd2,
        REG_IEN   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/nplus1_down_counter.sv
// Down-counter with n-plus-one expiry, one-shot and periodic modes.
// Assumes tick_en is a single-cycle pulse per timebase tick; a load in
// the same cycle as a tick takes precedence and suppresses that tick.
module nplus1_down_counter #(
    parameter int CNT_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load,
    input  logic             load_run,
    input  logic             load_periodic,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             run,
    output logic             periodic,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // Expiry: a tick arrives while running with the count already at zero.
    always_comb begin
        expire = run && tick_en && (count == '0) && !load;
    end

    // Counter, reload value, mode and run state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            reload   <= '0;
            run      <= 1'b0;
            periodic <= 1'b0;
        end else if (load) begin
            if (load_run) begin
                count    <= load_val;
                reload   <= load_val;
                periodic <= load_periodic;
                run      <= 1'b1;
            end else begin
                run      <= 1'b0;
            end
        end else if (expire) begin
            if (periodic) begin
                count <= reload;
            end else begin
                run   <= 1'b0;
            end
        end else if (run && tick_en) begin
            count <= count - ONE;
        end
    end
endmodule

// File: rtl/nplus1_irq_flag.sv
// Sticky expiry flag with write-one-to-clear and an interrupt enable.
// Assumes set and clr may coincide; set wins so no expiry is lost.
module nplus1_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ien_we,
    input  logic ien_wdata,
    output logic flag,
    output logic ien,
    output logic irq
);
    // Sticky flag: set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien <= 1'b0;
        end else if (ien_we) begin
            ien <= ien_wdata;
        end
    end

    // Interrupt pin is the flag gated by the enable.
    always_comb begin
        irq = flag & ien;
    end
endmodule

// File: rtl/nplus1_timer.sv
// Top level of the n-plus-one event timer: bus decode, read mux and the
// counter and flag sub-blocks. Assumes CNT_W is at most 29 so that the
// count field stays clear of the mode and run bits.
module nplus1_timer
    import nplus1_timer_pkg::*;
#(
    parameter int CNT_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CTRL_PAD = MODE_BIT - CNT_W;
    localparam int CNT_PAD  = DATA_W - CNT_W;

    logic             wr_ctrl, clr_flag, wr_ien;
    logic [CNT_W-1:0] ctr_count, ctr_reload;
    logic             ctr_run, ctr_periodic, ctr_expire;
    logic             flag_q, ien_q;
    logic             unused_wdata;

    // Write decode for the three writable registers.
    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
        clr_flag = bus_wr && (bus_addr == REG_STAT) && bus_wdata[FLAG_BIT];
        wr_ien   = bus_wr && (bus_addr == REG_IEN);
    end

    // Data bits that no register uses.
    assign unused_wdata = ^bus_wdata;

    nplus1_down_counter #(.CNT_W(CNT_W)) u_counter (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_en       (tick_en),
        .load          (wr_ctrl),
        .load_run      (bus_wdata[RUN_BIT]),
        .load_periodic (bus_wdata[MODE_BIT]),
        .load_val      (bus_wdata[CNT_W-1:0]),
        .count         (ctr_count),
        .reload        (ctr_reload),
        .run           (ctr_run),
        .periodic      (ctr_periodic),
        .expire        (ctr_expire)
    );

    nplus1_irq_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (ctr_expire),
        .clr       (clr_flag),
        .ien_we    (wr_ien),
        .ien_wdata (bus_wdata[0]),
        .flag      (flag_q),
        .ien       (ien_q),
        .irq       (irq)
    );

    // Read mux selected by the bus address.
    always_comb begin
        unique case (bus_addr)
            REG_CTRL:  bus_rdata = {ctr_run, ctr_periodic, {CTRL_PAD{1'b0}}, ctr_reload};
            REG_COUNT: bus_rdata = {{CNT_PAD{1'b0}}, ctr_count};
            REG_STAT:  bus_rdata = {1'b0, flag_q, {FLAG_BIT{1'b0}}};
            default:   bus_rdata = {{(DATA_W-1){1'b0}}, ien_q};
        endcase
    end
endmodule

// File: rtl/nplus1_timer_chk.sv
// Property checker for the n-plus-one event timer, bound to the top.
// Observes the counter and flag state between the sub-blocks.
module nplus1_timer_chk #(
    parameter int CNT_W = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             load,
    input logic             expire,
    input logic             run,
    input logic             periodic,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             flag,
    input logic             clr
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run && tick_en && !load && (count != '0) |=> count == $past(count) - ONE);

    p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en && !load |=> $stable(count));

    p_flag_on_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    p_oneshot_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !periodic && !load |=> !run && (count == '0));

    p_periodic_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire && periodic && !load |=> run && (count == reload));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);

    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= reload);
endmodule

bind nplus1_timer nplus1_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load     (wr_ctrl),
    .expire   (ctr_expire),
    .run      (ctr_run),
    .periodic (ctr_periodic),
    .count    (ctr_count),
    .reload   (ctr_reload),
    .flag     (flag_q),
    .clr      (clr_flag)
);

// File: tb/test_nplus1_timer.sv
module test_nplus1_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_tests = 0;
    int          n_fail = 0;

    localparam logic [31:0] FLAG = 32'h4000_0000;

    always #5 clk = ~clk;

    nplus1_timer i_nplus1_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], d);
            chk("R1 reset read", d, 32'd0);
        end
        chk("R1 reset irq", {31'd0, irq}, 32'd0);

        wr(2'd3, 32'd1);

        // R3 R4 R6: one-shot sweep over every load value 0..24
        for (int n = 0; n <= 24; n++) begin
            wr(2'd2, FLAG);
            wr(2'd0, 32'h8000_0000 | n);
            rd(2'd1, d);
            chk("R2 R11 load count", d, n);
            for (int k = 1; k <= n + 1; k++) begin
                tick();
                rd(2'd1, d);
                chk("R3 R11 live count", d, (k <= n) ? (n - k) : 0);
                rd(2'd2, d);
                chk((n == 0) ? "R4 first tick flag" : "R3 flag timing", d,
                    (k == n + 1) ? FLAG : 32'd0);
            end
            chk("R9 irq on expiry", {31'd0, irq}, 32'd1);
            rd(2'd0, d);
            chk("R6 run cleared", d, n);
            wr(2'd2, FLAG);
            rd(2'd2, d);
            chk("R8 w1c clear", d, 32'd0);
            chk("R9 irq low after clear", {31'd0, irq}, 32'd0);
            for (int k = 0; k < 2; k++) tick();
            rd(2'd2, d);
            chk("R6 no re-expiry", d, 32'd0);
            rd(2'd1, d);
            chk("R6 count held at zero", d, 32'd0);
        end

        // R7: periodic sweep over load values 0..5, three periods each
        for (int n = 0; n <= 5; n++) begin
            wr(2'd0, 32'hC000_0000 | n);
            for (int t = 1; t <= 3 * (n + 1); t++) begin
                tick();
                rd(2'd1, d);
                chk("R7 periodic count", d, ((t % (n + 1)) == 0) ? n : (n - (t % (n + 1))));
                rd(2'd2, d);
                chk("R7 periodic flag", d, ((t % (n + 1)) == 0) ? FLAG : 32'd0);
                if ((t % (n + 1)) == 0) wr(2'd2, FLAG);
            end
            rd(2'd0, d);
            chk("R7 still running", d, 32'hC000_0000 | n);
        end

        // R10: stop mid-count freezes count, no expiry
        wr(2'd0, 32'h8000_000A);
        for (int k = 0; k < 3; k++) tick();
        wr(2'd0, 32'h4000_0003);
        for (int k = 0; k < 20; k++) tick();
        rd(2'd1, d);
        chk("R10 count frozen", d, 32'd7);
        rd(2'd2, d);
        chk("R10 no expiry", d, 32'd0);
        rd(2'd0, d);
        chk("R10 fields ignored", d, 32'h0000_000A);

        // R5: idle clocks do not count; held tick counts each cycle
        wr(2'd0, 32'h8000_0008);
        repeat (6) @(negedge clk);
        rd(2'd1, d);
        chk("R5 no tick no change", d, 32'd8);
        @(negedge clk); tick_en = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        rd(2'd1, d);
        chk("R5 held tick", d, 32'd5);

        // R2: bit 29 ignored in the load word
        wr(2'd0, 32'hA000_0005);
        rd(2'd1, d);
        chk("R2 bit29 ignored", d, 32'd5);

        // R8 R9: write of zero ignored, enable gates irq
        wr(2'd0, 32'h8000_0000);
        tick();
        wr(2'd2, 32'hBFFF_FFFF);
        rd(2'd2, d);
        chk("R8 zero write ignored", d, FLAG);
        wr(2'd3, 32'd0);
        chk("R9 irq gated off", {31'd0, irq}, 32'd0);
        wr(2'd3, 32'd1);
        chk("R9 irq gated on", {31'd0, irq}, 32'd1);

        // R8: expiry coincident with clear leaves flag set
        wr(2'd2, FLAG);
        wr(2'd0, 32'h8000_0000);
        @(negedge clk);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = FLAG;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0; bus_wdata = 32'd0;
        rd(2'd2, d);
        chk("R8 set wins over clear", d, FLAG);

        // R12: full 29-bit load
        wr(2'd0, 32'h9FFF_FFFF);
        rd(2'd1, d);
        chk("R12 max load", d, 32'h1FFF_FFFF);
        rd(2'd0, d);
        chk("R12 max readback", d, 32'h9FFF_FFFF);
        tick();
        rd(2'd1, d);
        chk("R12 max decrement", d, 32'h1FFF_FFFE);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule